// File: doc/BRIEF.md
# Ethernet Receive Deframer with Length-Driven Pad Removal

This block sits between a line decoder and a receive FIFO. It takes one recovered bit per clock, qualified by a carrier-valid input. It drops the first few bits of each carrier burst, looks for the start-of-frame delimiter and packs the following bits into bytes. Each byte is then either written to the FIFO or held back. A running CRC-32 covers every byte after the delimiter.

When pad removal is enabled and the 16-bit length field holds a short payload size, only the header and the real payload reach the FIFO. The pad and the frame check sequence are still fed to the CRC. When carrier drops, the block raises an end-of-frame strobe and reports the forwarded byte count and the CRC verdict. It also tells the FIFO either to keep the frame or to roll it back. Frames that are too short or that see a collision early are rolled back, unless runts are accepted.

Top module: `eth_rx_deframer`

## Requirements
- R1: The first 8 bits sampled after `rx_valid` rises are ignored. The delimiter search starts with the 9th bit, so the earliest possible delimiter match is on the 16th bit of the burst.
- R2: The delimiter is the bit sequence 1,0,1,0,1,0,1,1 in arrival order. Later bits are packed least significant bit first, so the delimiter reads as byte 0xD5. Each complete byte that is kept gives one `fifo_wr` pulse with the unmodified byte on `fifo_data`.
- R3: If carrier drops before a delimiter is found, no write, strobe, commit or discard is produced.
- R4: Byte indexes count from 0 after the delimiter. The length field is byte 12 (high) and byte 13 (low). `strip_en` is sampled when the delimiter is found. When it is set and the length is below 46, only bytes 0 to 13+length are written. Bytes 0 to 13 are always written.
- R5: When `strip_en` is clear, or the length is 46 or more, every received byte including the 4 check bytes is written.
- R6: The CRC-32 (reflected polynomial 0xEDB88320, seed all ones) runs over every received byte, including bytes that were withheld. The check passes when the final register, read bit-reversed, equals 0xC704DD7B. `crc_err` is updated only with `eof`.
- R7: On the clock after carrier is first sampled low inside a frame, `eof` pulses for one cycle. In the same cycle `frame_len` holds the number of bytes written and exactly one of `fifo_commit` or `fifo_discard` is set. Trailing bits that do not complete a byte are dropped.
- R8: A frame with fewer than 64 bytes after the delimiter is discarded, unless `runt_ok` (sampled at the delimiter) is set.
- R9: A `collision` sampled inside a frame while fewer than 64 bytes have completed causes a discard, unless `runt_ok` is set. A collision at or after 64 bytes has no effect.
- R10: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one line bit per cycle while valid |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Carrier present; `rx_bit` is valid |
| rx_bit | input | 1 | Decoded line bit |
| collision | input | 1 | Collision seen on the medium |
| strip_en | input | 1 | Enable length-driven pad and check removal |
| runt_ok | input | 1 | Keep short and collided frames |
| fifo_wr | output | 1 | Write strobe for one byte |
| fifo_data | output | 8 | Byte to write |
| fifo_commit | output | 1 | Keep the frame just written |
| fifo_discard | output | 1 | Roll back the frame just written |
| eof | output | 1 | End-of-frame strobe |
| crc_err | output | 1 | Check sequence mismatch, valid with `eof` |
| frame_len | output | 16 | Bytes written for the frame, valid with `eof` |

## Verification
On every cycle the assertions check several things. A delimiter never matches before the skip window plus eight bits. Each end strobe carries exactly one outcome, and no outcome appears without a strobe. The forwarded count never exceeds the received count or the header-plus-length limit. Short frames without runt acceptance are always discarded. The CRC flag changes only at frame end. Only the bench scenarios can show whether the right bytes arrive in the right order, whether the CRC verdict is correct for good and corrupted frames, and whether a decoy delimiter inside the skipped bits and collisions on either side of the 64-byte mark are handled correctly.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SKIP  = 2'd1,
    ST_HUNT  = 2'd2,
    ST_FRAME = 2'd3
  } rx_state_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_GOOD_RES  = 32'hC704DD7B;

  // one byte into a reflected CRC-32 register
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [31:0] bit_reverse32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  // is byte number idx written to the FIFO
  function automatic logic keep_byte(input logic [31:0] idx, input logic strip_act,
                                     input logic [31:0] len, input logic [31:0] hdr);
    return (idx < hdr) || !strip_act || (idx < hdr + len);
  endfunction

endpackage

// File: rtl/eth_rx_align.sv
module eth_rx_align
  import eth_rx_pkg::*;
#(
  parameter int SKIP_BITS = 8,
  parameter logic [7:0] SFD = 8'hD5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic       rx_bit,
  output logic       sof,
  output logic       byte_stb,
  output logic [7:0] byte_val,
  output logic       frame_end,
  output logic       in_frame
);

  localparam int SKW = $clog2(SKIP_BITS) + 1;
  localparam int CBW = $clog2(SKIP_BITS + 9) + 1;
  localparam logic [SKW-1:0] SKIP_LAST = SKW'(SKIP_BITS - 1);
  localparam logic [CBW-1:0] CB_MAX = '1;

  rx_state_e      state;
  logic [7:0]     sh;
  logic [7:0]     shifted;
  logic [2:0]     bitpos;
  logic [SKW-1:0] skip_cnt;
  logic [CBW-1:0] carrier_bits;  // bits seen in this burst, for the checker

  assign shifted   = {rx_bit, sh[7:1]};
  assign sof       = (state == ST_HUNT) && rx_valid && (shifted == SFD);
  assign byte_stb  = (state == ST_FRAME) && rx_valid && (bitpos == 3'd7);
  assign byte_val  = shifted;
  assign frame_end = (state == ST_FRAME) && !rx_valid;
  assign in_frame  = (state == ST_FRAME);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sh       <= '0;
      bitpos   <= '0;
      skip_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (rx_valid) begin
          skip_cnt <= SKW'(1);
          sh       <= '0;
          state    <= (SKIP_BITS <= 1) ? ST_HUNT : ST_SKIP;
        end
        ST_SKIP: begin
          if (!rx_valid) state <= ST_IDLE;
          else if (skip_cnt == SKIP_LAST) state <= ST_HUNT;
          else skip_cnt <= skip_cnt + SKW'(1);
        end
        ST_HUNT: begin
          if (!rx_valid) state <= ST_IDLE;
          else begin
            sh <= shifted;
            if (shifted == SFD) begin
              state  <= ST_FRAME;
              bitpos <= '0;
            end
          end
        end
        default: begin
          if (!rx_valid) state <= ST_IDLE;
          else begin
            sh     <= shifted;
            bitpos <= bitpos + 3'd1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_valid) carrier_bits <= '0;
    else if (carrier_bits != CB_MAX) carrier_bits <= carrier_bits + CBW'(1);
  end

  // R1: delimiter only after the skipped bits plus eight search bits
  assert_sfd_after_skip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> (carrier_bits >= CBW'(SKIP_BITS + 7)));

endmodule

// File: rtl/eth_rx_crc.sv
module eth_rx_crc
  import eth_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sof,
  input  logic       byte_stb,
  input  logic [7:0] byte_val,
  output logic       crc_good
);

  logic [31:0] crc;

  assign crc_good = (bit_reverse32(crc) == CRC_GOOD_RES);

  always_ff @(posedge clk) begin
    if (!rst_n)        crc <= '1;
    else if (sof)      crc <= '1;
    else if (byte_stb) crc <= crc32_step(crc, byte_val);
  end

endmodule

// File: rtl/eth_rx_gate.sv
module eth_rx_gate
  import eth_rx_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int HDR_BYTES   = 14,
  parameter int MIN_PAYLOAD = 46,
  parameter int MIN_FRAME   = 64,
  parameter int LEN_POS     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             byte_stb,
  input  logic [7:0]       byte_val,
  input  logic             frame_end,
  input  logic             in_frame,
  input  logic             collision,
  input  logic             strip_en,
  input  logic             runt_ok,
  input  logic             crc_good,
  output logic             fifo_wr,
  output logic [7:0]       fifo_data,
  output logic             fifo_commit,
  output logic             fifo_discard,
  output logic             eof,
  output logic             crc_err,
  output logic [CNT_W-1:0] frame_len
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] MIN_C    = CNT_W'(MIN_FRAME);
  localparam logic [CNT_W-1:0] LEN_HI_C = CNT_W'(LEN_POS);
  localparam logic [CNT_W-1:0] LEN_LO_C = CNT_W'(LEN_POS + 1);
  localparam logic [15:0]      PAY_C    = 16'(MIN_PAYLOAD);

  logic [CNT_W-1:0] byte_cnt, fwd_cnt;
  logic [15:0]      len_q;
  logic             strip_lat, rok_lat, coll_q;
  logic             strip_act, keep, drop;

  assign strip_act = strip_lat && (len_q < PAY_C);
  assign keep      = keep_byte(32'(byte_cnt), strip_act, 32'(len_q), 32'(HDR_BYTES));
  assign drop      = ((byte_cnt < MIN_C) || coll_q) && !rok_lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_cnt <= '0; fwd_cnt <= '0; len_q <= '0;
      strip_lat <= 1'b0; rok_lat <= 1'b0; coll_q <= 1'b0;
      fifo_wr <= 1'b0; fifo_data <= '0; fifo_commit <= 1'b0; fifo_discard <= 1'b0;
      eof <= 1'b0; crc_err <= 1'b0; frame_len <= '0;
    end else begin
      fifo_wr      <= 1'b0;
      fifo_commit  <= 1'b0;
      fifo_discard <= 1'b0;
      eof          <= 1'b0;
      if (sof) begin
        byte_cnt  <= '0;
        fwd_cnt   <= '0;
        len_q     <= '0;
        strip_lat <= strip_en;
        rok_lat   <= runt_ok;
        coll_q    <= 1'b0;
      end else begin
        if (in_frame && collision && (byte_cnt < MIN_C)) coll_q <= 1'b1;
        if (byte_stb) begin
          if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + CNT_W'(1);
          if (byte_cnt == LEN_HI_C) len_q[15:8] <= byte_val;
          if (byte_cnt == LEN_LO_C) len_q[7:0]  <= byte_val;
          if (keep) begin
            fifo_wr   <= 1'b1;
            fifo_data <= byte_val;
            if (fwd_cnt != CNT_MAX) fwd_cnt <= fwd_cnt + CNT_W'(1);
          end
        end
        if (frame_end) begin
          eof          <= 1'b1;
          frame_len    <= fwd_cnt;
          crc_err      <= !crc_good;
          fifo_discard <= drop;
          fifo_commit  <= !drop;
        end
      end
    end
  end

  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> (fifo_commit != fifo_discard));
  assert_outcome_needs_eof_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_commit || fifo_discard) |-> eof);
  assert_no_write_at_eof_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_wr && eof));
  assert_fwd_within_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_cnt <= byte_cnt);
  assert_strip_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && strip_act) |-> (32'(frame_len) <= 32'(HDR_BYTES) + 32'(len_q)));
  assert_runt_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && (byte_cnt < MIN_C) && !rok_lat) |-> fifo_discard);
  assert_crc_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !eof |-> $stable(crc_err));

endmodule

// File: rtl/eth_rx_deframer.sv
module eth_rx_deframer
  import eth_rx_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SKIP_BITS   = 8,
  parameter int HDR_BYTES   = 14,
  parameter int MIN_PAYLOAD = 46,
  parameter int MIN_FRAME   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_bit,
  input  logic             collision,
  input  logic             strip_en,
  input  logic             runt_ok,
  output logic             fifo_wr,
  output logic [7:0]       fifo_data,
  output logic             fifo_commit,
  output logic             fifo_discard,
  output logic             eof,
  output logic             crc_err,
  output logic [CNT_W-1:0] frame_len
);

  localparam int LEN_POS = HDR_BYTES - 2;

  logic       sof, byte_stb, frame_end, in_frame, crc_good;
  logic [7:0] byte_val;

  eth_rx_align #(.SKIP_BITS(SKIP_BITS), .SFD(8'hD5)) u_align (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .sof(sof), .byte_stb(byte_stb), .byte_val(byte_val),
    .frame_end(frame_end), .in_frame(in_frame)
  );

  eth_rx_crc u_crc (
    .clk(clk), .rst_n(rst_n), .sof(sof), .byte_stb(byte_stb),
    .byte_val(byte_val), .crc_good(crc_good)
  );

  eth_rx_gate #(
    .CNT_W(CNT_W), .HDR_BYTES(HDR_BYTES), .MIN_PAYLOAD(MIN_PAYLOAD),
    .MIN_FRAME(MIN_FRAME), .LEN_POS(LEN_POS)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .sof(sof), .byte_stb(byte_stb), .byte_val(byte_val),
    .frame_end(frame_end), .in_frame(in_frame), .collision(collision),
    .strip_en(strip_en), .runt_ok(runt_ok), .crc_good(crc_good),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_commit(fifo_commit),
    .fifo_discard(fifo_discard), .eof(eof), .crc_err(crc_err), .frame_len(frame_len)
  );

endmodule

// File: tb/eth_rx_deframer_test.sv
module eth_rx_deframer_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_bit = 1'b0, collision = 1'b0, strip_en = 1'b0, runt_ok = 1'b0;
  logic fifo_wr, fifo_commit, fifo_discard, eof, crc_err;
  logic [7:0] fifo_data;
  logic [15:0] frame_len;

  always #5 clk = ~clk;

  eth_rx_deframer uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .collision(collision), .strip_en(strip_en), .runt_ok(runt_ok),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_commit(fifo_commit),
    .fifo_discard(fifo_discard), .eof(eof), .crc_err(crc_err), .frame_len(frame_len)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] fb  [0:255];
  logic [7:0] mon [0:255];
  int mon_n = 0, eof_n = 0, cm_n = 0;
  logic m_commit = 0, m_discard = 0, m_crc = 0;
  logic [15:0] m_len = 0;

  always @(negedge clk) begin
    if (fifo_wr && mon_n < 256) begin mon[mon_n] = fifo_data; mon_n++; end
    if (fifo_commit || fifo_discard) cm_n++;
    if (eof) begin
      eof_n++; m_commit = fifo_commit; m_discard = fifo_discard;
      m_crc = crc_err; m_len = frame_len;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // frame check value, one bit at a time over the whole message
  function automatic logic [31:0] bench_fcs(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < n * 8; k++) begin
      logic fbk;
      fbk = c[0] ^ fb[k / 8][k % 8];
      c = {1'b0, c[31:1]} ^ (fbk ? 32'hEDB8_8320 : 32'h0);
    end
    return ~c;
  endfunction

  task automatic build(input int n, input int len, input bit corrupt);
    logic [31:0] f;
    for (int i = 0; i < n - 4; i++) fb[i] = 8'($urandom);
    fb[12] = len[15:8];
    fb[13] = len[7:0];
    f = bench_fcs(n - 4);
    fb[n-4] = f[7:0];  fb[n-3] = f[15:8];
    fb[n-2] = f[23:16]; fb[n-1] = f[31:24];
    if (corrupt) fb[3] = fb[3] ^ 8'h10;
  endtask

  task automatic put_bit(input logic b, input logic c);
    @(negedge clk);
    rx_valid = 1'b1; rx_bit = b; collision = c;
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int b = 0; b < 8; b++) put_bit(v[b], 1'b0);
  endtask

  task automatic idle(input int cyc);
    @(negedge clk);
    rx_valid = 1'b0; rx_bit = 1'b0; collision = 1'b0;
    repeat (cyc) @(negedge clk);
  endtask

  function automatic int exp_fwd(input int n, input bit strip);
    int len;
    if (n < 14) return n;
    len = {fb[12], fb[13]};
    if (strip && len < 46) return (n < 14 + len) ? n : 14 + len;
    return n;
  endfunction

  // send one frame and compare with the expected outcome
  task automatic run(input string tag, input int n, input bit strip, input bit rok,
                     input bit corrupt, input bit decoy, input int coll_k, input int dribble);
    int ef; bit exp_drop; bit same;
    @(negedge clk);
    strip_en = strip; runt_ok = rok;
    mon_n = 0; eof_n = 0; cm_n = 0;
    if (decoy) begin
      put_byte(8'hD5); put_byte(8'h55); put_byte(8'h55); put_byte(8'h55);
    end else
      for (int i = 0; i < 7; i++) put_byte(8'h55);
    put_byte(8'hD5);
    for (int k = 0; k < n * 8; k++) put_bit(fb[k / 8][k % 8], k == coll_k);
    for (int k = 0; k < dribble; k++) put_bit(1'b1, 1'b0);
    idle(5);
    ef = exp_fwd(n, strip);
    exp_drop = ((n < 64) || (coll_k >= 0 && coll_k < n * 8 && coll_k / 8 < 64)) && !rok;
    same = (mon_n == ef);
    for (int i = 0; i < ef && i < mon_n; i++) if (mon[i] !== fb[i]) same = 0;
    chk(same, "R2", {tag, " forwarded bytes (count shown)"}, mon_n, ef);
    chk(mon_n == ef, (strip ? "R4" : "R5"), {tag, " write count"}, mon_n, ef);
    chk(eof_n == 1 && cm_n == 1, "R7", {tag, " strobe count"}, eof_n, 1);
    chk(m_len == 16'(ef), "R7", {tag, " frame_len"}, int'(m_len), ef);
    chk(m_crc == corrupt, "R6", {tag, " crc_err"}, int'(m_crc), int'(corrupt));
    chk(m_discard == exp_drop && m_commit == !exp_drop,
        (coll_k >= 0) ? "R9" : "R8", {tag, " discard"}, int'(m_discard), int'(exp_drop));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk({fifo_wr, fifo_commit, fifo_discard, eof, crc_err} == 5'b0 && frame_len == 0 && fifo_data == 0,
        "R10", "outputs in reset", int'({fifo_wr, fifo_commit, fifo_discard, eof, crc_err}), 0);
    rst_n = 1'b1;
    idle(3);
    chk({fifo_wr, fifo_commit, fifo_discard, eof} == 4'b0, "R10", "outputs after reset", int'(eof), 0);

    // R1: a delimiter inside the skipped bits must not start the frame
    build(64, 16'h0800, 0); run("R1 decoy", 64, 1, 0, 0, 1, -1, 0);
    build(64, 10, 0);  run("R4 strip len10", 64, 1, 0, 0, 0, -1, 0);
    build(64, 10, 0);  run("R5 nostrip len10", 64, 0, 0, 0, 0, -1, 0);
    build(64, 46, 0);  run("R5 len46", 64, 1, 0, 0, 0, -1, 0);
    build(64, 0, 0);   run("R4 len0", 64, 1, 0, 0, 0, -1, 0);
    build(64, 5, 1);   run("R6 bad crc stripped", 64, 1, 0, 1, 0, -1, 0);
    build(90, 200, 1); run("R6 bad crc long", 90, 0, 0, 1, 0, -1, 0);
    build(40, 20, 0);  run("R8 runt", 40, 0, 0, 0, 0, -1, 0);
    build(40, 20, 0);  run("R8 runt kept", 40, 1, 1, 0, 0, -1, 0);
    build(63, 46, 0);  run("R8 63 bytes", 63, 0, 0, 0, 0, -1, 0);
    build(80, 100, 0); run("R9 early coll", 80, 0, 0, 0, 0, 100, 0);
    build(80, 100, 0); run("R9 early coll kept", 80, 0, 1, 0, 0, 100, 0);
    build(80, 100, 0); run("R9 late coll", 80, 0, 0, 0, 0, 520, 0);
    build(64, 30, 0);  run("R7 dribble", 64, 1, 0, 0, 0, -1, 3);

    // R3: carrier lost during the search
    mon_n = 0; eof_n = 0; cm_n = 0;
    for (int i = 0; i < 20; i++) put_bit(i % 2 == 0, 1'b0);
    idle(5);
    chk(mon_n == 0 && eof_n == 0 && cm_n == 0, "R3", "activity without delimiter", eof_n + mon_n + cm_n, 0);

    for (int t = 0; t < 20; t++) begin
      int n, len; bit s, r, c;
      n = 18 + int'($urandom % 103);
      len = ($urandom % 2) ? int'($urandom % 46) : 46 + int'($urandom % 1500);
      s = 1'($urandom); r = 1'($urandom); c = ($urandom % 4) == 0;
      build(n, len, c);
      run("random", n, s, r, c, 0, -1, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule